// File: doc/BRIEF.md
# Sun Sensor Acquisition/Tracking Sequencer

This block is the top-level controller of a pixel-array sun sensor. It alternates between two modes. In acquisition mode it repeatedly launches a whole-array profiling pass. When a pass reports a sun spot, it switches to tracking mode. In tracking mode it repeatedly launches readouts of a fixed square window centred on the coarse spot location. After two dim tracking frames in a row it declares the sun lost and returns to acquisition.

Each mode has its own integration time. A command port writes these two settings into shadow registers. The value driven to the pixel array is taken from the shadow of the mode that owns the frame, and it is loaded only as that frame starts. The straps give the power-on values of both integration times and the 2-bit report-rate code.

A report pacer divides the clock into report slots. At each slot it offers a one-bit report on a valid/ready stream. The report flags whether the sensor is tracking. A report that is not yet accepted holds its payload. Report slots that fall while a report is pending are discarded, so stale reports never queue up. The pacer keeps its original slot grid regardless of when the consumer accepts.

Top module: `sunseq_top`

## Requirements
- R1: During and directly after reset, `mode` is 0 (acquisition), `prof_start` is 1, `win_start` is 0, `report_valid` is 0 and `itime_out` equals `strap_itime_acq`.
- R2: A profiling result with `sun_found`=0 keeps `mode` at 0 and gives a new one-cycle `prof_start` in the cycle after `prof_done`.
- R3: A profiling result with `sun_found`=1 sets `mode` to 1 and gives a `win_start` pulse in the cycle after `prof_done`. Window origin `win_x`/`win_y` = coarse coordinate minus 12 (half the 25-pixel window).
- R4: The window origin is clamped to the range 0 to 343, so the 25-pixel window always fits inside the 368-pixel array.
- R5: A tracking result with `win_bright`=0 after a bright frame keeps tracking and starts a new window. A bright frame resets the dim-frame count.
- R6: The second consecutive tracking result with `win_bright`=0 sets `mode` to 0 and gives a `prof_start` in the next cycle.
- R7: `cmd_sel`=0 writes the acquisition shadow and `cmd_sel`=1 writes the tracking shadow. At each frame start, `itime_out` takes the shadow value of that frame's mode.
- R8: `itime_out` changes only when a new frame starts. A command write never alters it while a frame is in progress.
- R9: Both shadows reset to their strap values. The first tracking frame after reset without writes uses `strap_itime_trk`.
- R10: Report slots come every `BASE_DIV`×M cycles, with M = 1, 5, 10, 20 for `strap_rate` 00, 01, 10, 11 (10, 2, 1, 0.5 Hz when `BASE_DIV` cycles make 0.1 s). The code is sampled during reset.
- R11: `report_valid` stays high with a stable `report_trk` until `report_ready`. Slots during a pending report are dropped. `report_trk` is the mode at the slot.
- R12: `prof_start` and `win_start` are single-cycle pulses. Done inputs that arrive during a start cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_rate | input | 2 | Report rate code, sampled in reset |
| strap_itime_acq | input | ITW | Power-on acquisition integration time |
| strap_itime_trk | input | ITW | Power-on tracking integration time |
| cmd_we | input | 1 | Command write strobe |
| cmd_sel | input | 1 | 0 = acquisition shadow, 1 = tracking shadow |
| cmd_data | input | ITW | Command write data |
| prof_start | output | 1 | Start profiling pass |
| prof_done | input | 1 | Profiling pass finished |
| sun_found | input | 1 | Sun present in profile, valid with prof_done |
| coarse_x | input | CW | Coarse spot column, valid with prof_done |
| coarse_y | input | CW | Coarse spot row, valid with prof_done |
| win_start | output | 1 | Start window readout |
| win_x | output | CW | Window origin column |
| win_y | output | CW | Window origin row |
| win_done | input | 1 | Window readout finished |
| win_bright | input | 1 | Window intensity above presence threshold |
| mode | output | 1 | 0 = acquisition, 1 = tracking |
| itime_out | output | ITW | Integration time for the current frame |
| report_valid | output | 1 | Report offered |
| report_ready | input | 1 | Report accepted |
| report_trk | output | 1 | Report payload: tracking flag |

## Verification
Mode, the start pulse, the window origin and `itime_out` change on the clock edge that samples a done pulse. The bench drives each done pulse for one cycle from a falling edge. It checks all four of these results at the next falling edge. A write is checked at the falling edge right after its capturing edge, which shows that `itime_out` has not moved. Report timing is measured as the cycle count between falling-edge samples of `report_valid`. The back-pressure release is placed so that it does not coincide with a report slot.

// File: rtl/sunseq_pkg.sv
package sunseq_pkg;

  typedef enum logic [1:0] {
    ST_ACQ_GO   = 2'd0,
    ST_ACQ_WAIT = 2'd1,
    ST_TRK_GO   = 2'd2,
    ST_TRK_WAIT = 2'd3
  } seq_state_e;

  // number of base slots per report, indexed by the strap code
  function automatic int unsigned rate_mult(input logic [1:0] code);
    case (code)
      2'b00:   return 1;
      2'b01:   return 5;
      2'b10:   return 10;
      default: return 20;
    endcase
  endfunction

endpackage

// File: rtl/sunseq_itime.sv
module sunseq_itime #(
  parameter int ITW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [ITW-1:0] strap_acq,
  input  logic [ITW-1:0] strap_trk,
  input  logic           cmd_we,
  input  logic           cmd_sel,
  input  logic [ITW-1:0] cmd_data,
  input  logic           load_en,
  input  logic           load_trk,
  output logic [ITW-1:0] itime
);

  localparam int NSH = 2;

  logic [ITW-1:0] shadow_q [NSH];
  logic [ITW-1:0] strap_v  [NSH];

  assign strap_v[0] = strap_acq;
  assign strap_v[1] = strap_trk;

  for (genvar g = 0; g < NSH; g++) begin : g_shadow
    always_ff @(posedge clk) begin
      if (rst)                                shadow_q[g] <= strap_v[g];
      else if (cmd_we && (cmd_sel == 1'(g)))  shadow_q[g] <= cmd_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          itime <= strap_acq;
    else if (load_en) itime <= load_trk ? shadow_q[1] : shadow_q[0];
  end

  // R8: applied value only moves when a frame is being launched
  a_r8_itime_hold: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> $stable(itime));

endmodule

// File: rtl/sunseq_ctrl.sv
module sunseq_ctrl
  import sunseq_pkg::*;
#(
  parameter int CW          = 9,
  parameter int ARRAY_DIM   = 368,
  parameter int WIN_DIM     = 25,
  parameter int LOST_FRAMES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          prof_done,
  input  logic          sun_found,
  input  logic [CW-1:0] coarse_x,
  input  logic [CW-1:0] coarse_y,
  input  logic          win_done,
  input  logic          win_bright,
  output logic          prof_start,
  output logic          win_start,
  output logic          mode_trk,
  output logic [CW-1:0] win_x,
  output logic [CW-1:0] win_y,
  output logic          load_en,
  output logic          load_trk
);

  localparam logic [CW-1:0] HALF = CW'(WIN_DIM / 2);
  localparam logic [CW-1:0] MAXO = CW'(ARRAY_DIM - WIN_DIM);
  localparam int            MW   = $clog2(LOST_FRAMES + 1);
  localparam logic [MW-1:0] LAST = MW'(LOST_FRAMES - 1);

  seq_state_e    state_q, nxt;
  logic [MW-1:0] miss_q;
  logic          dim_frame, sun_lost, acquired;

  function automatic logic [CW-1:0] place(input logic [CW-1:0] c);
    logic [CW-1:0] d;
    if (c < HALF) return '0;
    d = c - HALF;
    return (d > MAXO) ? MAXO : d;
  endfunction

  assign dim_frame = (state_q == ST_TRK_WAIT) && win_done && !win_bright;
  assign sun_lost  = dim_frame && (miss_q == LAST);
  assign acquired  = (state_q == ST_ACQ_WAIT) && prof_done && sun_found;

  always_comb begin
    nxt = state_q;
    case (state_q)
      ST_ACQ_GO:   nxt = ST_ACQ_WAIT;
      ST_ACQ_WAIT: if (prof_done) nxt = sun_found ? ST_TRK_GO : ST_ACQ_GO;
      ST_TRK_GO:   nxt = ST_TRK_WAIT;
      ST_TRK_WAIT: if (win_done)  nxt = sun_lost ? ST_ACQ_GO : ST_TRK_GO;
      default:     nxt = ST_ACQ_GO;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_ACQ_GO;
    else     state_q <= nxt;
  end

  always_ff @(posedge clk) begin
    if (rst)                                      miss_q <= '0;
    else if (state_q == ST_TRK_WAIT && win_done)  miss_q <= (win_bright || sun_lost) ? '0 : miss_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_x <= '0;
      win_y <= '0;
    end else if (acquired) begin
      win_x <= place(coarse_x);
      win_y <= place(coarse_y);
    end
  end

  assign prof_start = (state_q == ST_ACQ_GO);
  assign win_start  = (state_q == ST_TRK_GO);
  assign mode_trk   = (state_q == ST_TRK_GO) || (state_q == ST_TRK_WAIT);
  assign load_en    = (nxt != state_q) && (nxt == ST_ACQ_GO || nxt == ST_TRK_GO);
  assign load_trk   = (nxt == ST_TRK_GO);

  a_r3_found_enters_track: assert property (@(posedge clk) disable iff (rst)
    (!mode_trk && !prof_start && prof_done && sun_found) |=> (win_start && mode_trk));
  a_r4_window_fits: assert property (@(posedge clk) disable iff (rst)
    (win_x <= MAXO) && (win_y <= MAXO));
  a_r5_single_dim_keeps: assert property (@(posedge clk) disable iff (rst)
    (mode_trk && !win_start && win_done && !win_bright && miss_q != LAST) |=> win_start);
  a_r6_lost_to_acq: assert property (@(posedge clk) disable iff (rst)
    (mode_trk && !win_start && win_done && !win_bright && miss_q == LAST) |=> (prof_start && !mode_trk));
  a_r12_prof_pulse: assert property (@(posedge clk) disable iff (rst)
    prof_start |=> !prof_start);
  a_r12_win_pulse: assert property (@(posedge clk) disable iff (rst)
    win_start |=> !win_start);

endmodule

// File: rtl/sunseq_pacer.sv
module sunseq_pacer
  import sunseq_pkg::*;
#(
  parameter int BASE_DIV = 100
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] strap_rate,
  input  logic       mode_trk,
  output logic       report_valid,
  input  logic       report_ready,
  output logic       report_trk
);

  localparam int BW = (BASE_DIV > 2) ? $clog2(BASE_DIV) : 1;
  localparam int MW = 5;

  logic [BW-1:0] base_q;
  logic [MW-1:0] mcnt_q, mlim_q;
  logic          base_hit, slot;

  assign base_hit = (base_q == BW'(BASE_DIV - 1));
  assign slot     = base_hit && (mcnt_q == mlim_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      mcnt_q <= '0;
      mlim_q <= MW'(rate_mult(strap_rate) - 1);
    end else begin
      base_q <= base_hit ? '0 : base_q + 1'b1;
      if (base_hit) mcnt_q <= (mcnt_q == mlim_q) ? '0 : mcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      report_valid <= 1'b0;
      report_trk   <= 1'b0;
    end else if (report_valid && !report_ready) begin
      report_valid <= 1'b1;
    end else if (slot) begin
      report_valid <= 1'b1;
      report_trk   <= mode_trk;
    end else begin
      report_valid <= 1'b0;
    end
  end

  a_r10_slot_spacing: assert property (@(posedge clk) disable iff (rst)
    slot |=> !slot);
  a_r11_hold_payload: assert property (@(posedge clk) disable iff (rst)
    (report_valid && !report_ready) |=> (report_valid && $stable(report_trk)));

endmodule

// File: rtl/sunseq_top.sv
module sunseq_top #(
  parameter int ITW         = 8,
  parameter int ARRAY_DIM   = 368,
  parameter int WIN_DIM     = 25,
  parameter int LOST_FRAMES = 2,
  parameter int BASE_DIV    = 100,
  parameter int CW          = $clog2(ARRAY_DIM)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [1:0]     strap_rate,
  input  logic [ITW-1:0] strap_itime_acq,
  input  logic [ITW-1:0] strap_itime_trk,
  input  logic           cmd_we,
  input  logic           cmd_sel,
  input  logic [ITW-1:0] cmd_data,
  output logic           prof_start,
  input  logic           prof_done,
  input  logic           sun_found,
  input  logic [CW-1:0]  coarse_x,
  input  logic [CW-1:0]  coarse_y,
  output logic           win_start,
  output logic [CW-1:0]  win_x,
  output logic [CW-1:0]  win_y,
  input  logic           win_done,
  input  logic           win_bright,
  output logic           mode,
  output logic [ITW-1:0] itime_out,
  output logic           report_valid,
  input  logic           report_ready,
  output logic           report_trk
);

  logic load_en, load_trk, mode_trk;

  sunseq_ctrl #(
    .CW(CW), .ARRAY_DIM(ARRAY_DIM), .WIN_DIM(WIN_DIM), .LOST_FRAMES(LOST_FRAMES)
  ) i_ctrl (
    .clk, .rst, .prof_done, .sun_found, .coarse_x, .coarse_y,
    .win_done, .win_bright, .prof_start, .win_start, .mode_trk,
    .win_x, .win_y, .load_en, .load_trk
  );

  sunseq_itime #(.ITW(ITW)) i_itime (
    .clk, .rst, .strap_acq(strap_itime_acq), .strap_trk(strap_itime_trk),
    .cmd_we, .cmd_sel, .cmd_data, .load_en, .load_trk, .itime(itime_out)
  );

  sunseq_pacer #(.BASE_DIV(BASE_DIV)) i_pacer (
    .clk, .rst, .strap_rate, .mode_trk, .report_valid, .report_ready, .report_trk
  );

  assign mode = mode_trk;

  // R1: reset leaves the block in acquisition with a profiling launch pending
  a_r1_reset_acq: assert property (@(posedge clk) rst |=> (!mode && prof_start && !report_valid));

endmodule

// File: tb/test_sunseq_top.sv
module test_sunseq_top;
  localparam int CLK_PERIOD = 10;
  localparam int BD  = 4;
  localparam int ITW = 8;
  localparam int CW  = 9;

  logic clk = 0, rst = 1;
  logic [1:0] strap_rate = 2'b00;
  logic [ITW-1:0] strap_itime_acq = 8'h11, strap_itime_trk = 8'h22;
  logic cmd_we = 0, cmd_sel = 0;
  logic [ITW-1:0] cmd_data = '0;
  logic prof_start, prof_done = 0, sun_found = 0;
  logic [CW-1:0] coarse_x = '0, coarse_y = '0;
  logic win_start, win_done = 0, win_bright = 0;
  logic [CW-1:0] win_x, win_y;
  logic mode, report_valid, report_ready = 1, report_trk;
  logic [ITW-1:0] itime_out;

  int checks = 0, fails = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sunseq_top #(.ITW(ITW), .BASE_DIV(BD)) i_sunseq_top (.*);

  typedef struct packed {
    logic kind; logic flag; logic [8:0] cx; logic [8:0] cy;
    logic emode; logic [8:0] ewx; logic [8:0] ewy;
  } vec_t;

  localparam vec_t VEC [14] = '{
    '{1'b0, 1'b0, 9'd0,   9'd0,   1'b0, 9'd0,   9'd0},   // R2 no sun
    '{1'b0, 1'b1, 9'd100, 9'd200, 1'b1, 9'd88,  9'd188}, // R3
    '{1'b1, 1'b1, 9'd0,   9'd0,   1'b1, 9'd88,  9'd188}, // R5 bright
    '{1'b1, 1'b0, 9'd0,   9'd0,   1'b1, 9'd88,  9'd188}, // R5 one dim
    '{1'b1, 1'b1, 9'd0,   9'd0,   1'b1, 9'd88,  9'd188}, // R5 count cleared
    '{1'b1, 1'b0, 9'd0,   9'd0,   1'b1, 9'd88,  9'd188},
    '{1'b1, 1'b0, 9'd0,   9'd0,   1'b0, 9'd0,   9'd0},   // R6 lost
    '{1'b0, 1'b1, 9'd5,   9'd3,   1'b1, 9'd0,   9'd0},   // R4 low clamp
    '{1'b1, 1'b0, 9'd0,   9'd0,   1'b1, 9'd0,   9'd0},
    '{1'b1, 1'b0, 9'd0,   9'd0,   1'b0, 9'd0,   9'd0},
    '{1'b0, 1'b1, 9'd367, 9'd360, 1'b1, 9'd343, 9'd343}, // R4 high clamp
    '{1'b1, 1'b0, 9'd0,   9'd0,   1'b1, 9'd343, 9'd343},
    '{1'b1, 1'b0, 9'd0,   9'd0,   1'b0, 9'd0,   9'd0},
    '{1'b0, 1'b1, 9'd12,  9'd355, 1'b1, 9'd0,   9'd343}  // R4 exact edges
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] rc);
    rst = 1; strap_rate = rc; prof_done = 0; win_done = 0; cmd_we = 0;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  task automatic frame_done(input logic kind, input logic flag, input logic [8:0] cx, input logic [8:0] cy);
    @(negedge clk);
    if (kind) begin win_done = 1; win_bright = flag; end
    else begin prof_done = 1; sun_found = flag; coarse_x = cx; coarse_y = cy; end
    @(negedge clk);
    win_done = 0; prof_done = 0;
  endtask

  task automatic wr(input logic sel, input logic [ITW-1:0] d);
    @(negedge clk);
    cmd_we = 1; cmd_sel = sel; cmd_data = d;
    @(negedge clk);
    cmd_we = 0;
  endtask

  task automatic wait_valid(output int t);
    t = -1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (report_valid) begin t = cyc; break; end
    end
  endtask

  task automatic rate_run(input logic [1:0] code, input int mult);
    int t0, t1;
    do_reset(code);
    wait_valid(t0);
    wait_valid(t1);
    check("R10 report period", t1 - t0, BD * mult);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int t0, t1;
    bit held;
    // R1 reset state
    do_reset(2'b11);
    check("R1 mode", mode, 0);
    check("R1 prof_start", prof_start, 1);
    check("R1 win_start", win_start, 0);
    check("R1 report_valid", report_valid, 0);
    check("R1 itime", itime_out, 8'h11);

    // table walk: R2..R6, R9
    for (int k = 0; k < 14; k++) begin
      frame_done(VEC[k].kind, VEC[k].flag, VEC[k].cx, VEC[k].cy);
      check("R2/R5/R6 mode", mode, VEC[k].emode);
      check("R12 start pulse", {prof_start, win_start}, VEC[k].emode ? 2'b01 : 2'b10);
      check("R9 itime from strap", itime_out, VEC[k].emode ? 8'h22 : 8'h11);
      if (VEC[k].emode) begin
        check("R3/R4 win_x", win_x, VEC[k].ewx);
        check("R3/R4 win_y", win_y, VEC[k].ewy);
      end
      @(negedge clk);
      check("R12 pulse ends", prof_start | win_start, 0);
    end

    // R7 R8 integration-time shadows
    do_reset(2'b11);
    wr(1'b1, 8'h5A);
    check("R8 itime held after trk write", itime_out, 8'h11);
    frame_done(1'b0, 1'b1, 9'd100, 9'd100);
    check("R7 trk shadow applied", itime_out, 8'h5A);
    wr(1'b0, 8'h33);
    wr(1'b1, 8'h44);
    check("R8 itime held mid track", itime_out, 8'h5A);
    frame_done(1'b1, 1'b0, 9'd0, 9'd0);
    check("R7 next trk frame", itime_out, 8'h44);
    frame_done(1'b1, 1'b0, 9'd0, 9'd0);
    check("R7 acq shadow applied", itime_out, 8'h33);
    check("R6 back to acq", mode, 0);

    // R12 done during start cycle is ignored
    do_reset(2'b11);
    prof_done = 1; sun_found = 1;
    @(negedge clk);
    prof_done = 0;
    check("R12 done in start cycle ignored", mode, 0);
    @(negedge clk);
    check("R12 no extra start", prof_start | win_start, 0);

    // R10 rate codes
    rate_run(2'b00, 1);
    rate_run(2'b01, 5);
    rate_run(2'b10, 10);
    rate_run(2'b11, 20);

    // R11 back-pressure
    do_reset(2'b01);
    report_ready = 0;
    wait_valid(t0);
    check("R11 acq payload", report_trk, 0);
    held = 1;
    repeat (25) begin
      @(negedge clk);
      if (!report_valid || report_trk) held = 0;
    end
    check("R11 held until ready", held, 1);
    report_ready = 1;
    @(negedge clk);
    check("R11 cleared, slot dropped", report_valid, 0);
    wait_valid(t1);
    check("R11 slot grid kept", t1 - t0, 40);

    // R11 tracking payload
    do_reset(2'b00);
    frame_done(1'b0, 1'b1, 9'd50, 9'd50);
    wait_valid(t0);
    check("R11 trk payload", report_trk, 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule